// File: doc/BRIEF.md
# Nested interrupt level controller

This block decides, on every clock, whether one of several pending peripheral interrupt requests may interrupt the program that is currently running. Each source carries a 2-bit programmable level, where a smaller number is more urgent. The running context is described by a global enable flag and a 2-bit current-level field. A request is taken only when interrupts are enabled, its level is a legal one (1 or 2), and that level is strictly more urgent than the current level. Because of this, a level-1 source can break into a level-2 handler, but a handler cannot be interrupted by a source of its own level.

When a request is taken, the block pulses a one-cycle strobe and reports the index of the winning source. It pushes the enable flag and current level onto an internal status stack, then loads the current level with the level of the winner. A return strobe pops the stack and restores the enable flag and level exactly. Between interrupts, software may overwrite the enable flag and level directly. The requesting peripheral clears its own request line.

The stack has a fixed depth. If a push is attempted while the stack is full, or a pop while it is empty, the block raises an error pulse for one cycle and leaves its state untouched.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable flag is 0, the current level is 3 (binary 11), and the take strobe, source index and error output are all 0.
- R2: While the enable flag is 0, no request is taken, whatever the levels of the requesting sources.
- R3: While the current level is 0, no request is taken, even with the enable flag at 1.
- R4: A source whose configured level is 3 or 0 is never taken. Source i's level sits in bits [2i+1:2i] of the level vector.
- R5: A request is taken only if its level is numerically lower than the current level. A level-1 request therefore preempts a level-2 handler, and a held request at the same level as the current one is not taken again.
- R6: When several sources qualify in the same cycle, the one with the lowest level number wins. Among sources with the same level, the lowest index wins.
- R7: A decision made at a clock edge appears in the following cycle. For one cycle the take strobe is 1 and the source index shows the winner. The current level equals the winner's level, and the enable flag is unchanged. In cycles with no take, the index reads 0.
- R8: A return strobe with a non-empty stack restores exactly the enable flag and level that were saved by the most recent take still on the stack.
- R9: A software write loads the enable flag and level at the next edge, and the next decision uses the new values. No request is taken in a cycle that carries a return strobe or a software write. A return strobe has priority over a write in the same cycle.
- R10: The stack holds STACK_DEPTH entries. A qualifying request that arrives while the stack is full is refused: the error output pulses for one cycle and the state is unchanged.
- R11: A return strobe with an empty stack pulses the error output for one cycle and leaves the enable flag and level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Pending request per source, held by the peripheral |
| irq_lvl | input | 2*NUM_SRC | Per-source level, source i in bits [2i+1:2i] |
| ccr_wr | input | 1 | Software write strobe for enable flag and level |
| ccr_ie_in | input | 1 | Enable flag value to write |
| ccr_il_in | input | 2 | Level value to write |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | One-cycle strobe: a request was taken |
| take_src | output | $clog2(NUM_SRC) | Index of the taken source |
| ccr_ie | output | 1 | Live enable flag |
| ccr_il | output | 2 | Live current level |
| stk_err | output | 1 | One-cycle pulse on stack overflow or underflow |

## Verification
The hardest situation to reach from the ports is a full status stack. With legal levels only, natural nesting stops after two takes. The stimulus therefore uses a software write inside each handler to lower the urgency of the current level again. That lets the same level-1 source be taken repeatedly until every stack slot is filled, and the next qualifying request then exercises the refusal path. The saved levels are varied from one push to the next, so the unwind sequence checks that the entries come back in reverse order, ending with one extra return that empties past the bottom.

// File: rtl/nic_pkg.sv
// Shared types for the nested interrupt level controller.
// Assumes 2-bit levels; level 0 and level 3 are never serviced.
package nic_pkg;
    localparam int LVL_W = 2;
    localparam logic [LVL_W-1:0] LVL_IDLE = 2'b11;
    localparam logic [LVL_W-1:0] LVL_MASK = 2'b00;

    typedef struct packed {
        logic             ie;
        logic [LVL_W-1:0] il;
    } nic_status_t;
endpackage

// File: rtl/nic_arbiter.sv
// Qualifies each request against the live status and picks one winner.
// Winner: lowest level number, then lowest index. Purely combinational.
// Assumes NUM_SRC >= 2.
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [LVL_W*NUM_SRC-1:0] lvl,
    input  nic_status_t              cur,
    output logic                     any_win,
    output logic [SRC_W-1:0]         win_idx,
    output logic [LVL_W-1:0]         win_lvl
);
    logic [NUM_SRC-1:0] qual;

    // Per-source qualification: enabled, legal level, strictly more urgent.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        localparam int LO = g * LVL_W;
        assign qual[g] = req[g] && cur.ie
                         && (lvl[LO +: LVL_W] != LVL_MASK)
                         && (lvl[LO +: LVL_W] != LVL_IDLE)
                         && (lvl[LO +: LVL_W] < cur.il);
    end

    // Selection scan: a strict compare keeps the lowest index on a tie.
    always_comb begin
        any_win = 1'b0;
        win_idx = '0;
        win_lvl = LVL_IDLE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (lvl[i*LVL_W +: LVL_W] < win_lvl)) begin
                any_win = 1'b1;
                win_idx = i[SRC_W-1:0];
                win_lvl = lvl[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/nic_stack.sv
// LIFO of saved status words. Push and pop are never requested together;
// the caller guarantees push only when not full and pop only when not empty.
module nic_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic        pop,
    input  nic_status_t push_data,
    output nic_status_t top_data,
    output logic        full,
    output logic        empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] ONE   = 1;
    localparam logic [CNT_W-1:0] LIMIT = DEPTH[CNT_W-1:0];

    nic_status_t      mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_m1;

    assign cnt_m1   = cnt - ONE;
    assign full     = (cnt == LIMIT);
    assign empty    = (cnt == '0);
    assign top_data = mem[cnt_m1[PTR_W-1:0]];

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (push) cnt <= cnt + ONE;
        else if (pop)  cnt <= cnt_m1;
    end

    // Entry storage; contents need no reset because the counter gates reads.
    always_ff @(posedge clk) begin
        if (push) mem[cnt[PTR_W-1:0]] <= push_data;
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
// Nested interrupt level controller top.
// Holds the live enable flag and level, arbitrates requests each cycle,
// saves/restores status through a LIFO. Priority per cycle:
// return strobe, then software write, then request acceptance.
// Assumes requests are cleared by the peripheral, not here.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int STACK_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_req,
    input  logic [2*NUM_SRC-1:0]       irq_lvl,
    input  logic                       ccr_wr,
    input  logic                       ccr_ie_in,
    input  logic [1:0]                 ccr_il_in,
    input  logic                       ret_strobe,
    output logic                       take,
    output logic [$clog2(NUM_SRC)-1:0] take_src,
    output logic                       ccr_ie,
    output logic [1:0]                 ccr_il,
    output logic                       stk_err
);
    localparam int SRC_W = $clog2(NUM_SRC);

    nic_status_t      cur;
    nic_status_t      saved;
    logic             any_win;
    logic [SRC_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic             stk_full;
    logic             stk_empty;
    logic             do_pop;
    logic             do_push;
    logic             err_nxt;
    logic             cand;

    nic_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) arb_i (
        .req     (irq_req),
        .lvl     (irq_lvl),
        .cur     (cur),
        .any_win (any_win),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    nic_stack #(.DEPTH(STACK_DEPTH)) stk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (cur),
        .top_data  (saved),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    // Command decode: commands suppress acceptance in their cycle.
    always_comb begin
        cand    = any_win && !ret_strobe && !ccr_wr;
        do_pop  = ret_strobe && !stk_empty;
        do_push = cand && !stk_full;
        err_nxt = (ret_strobe && stk_empty) || (cand && stk_full);
    end

    // Live status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.ie <= 1'b0;
            cur.il <= LVL_IDLE;
        end else if (do_pop) begin
            cur <= saved;
        end else if (ccr_wr && !ret_strobe) begin
            cur.ie <= ccr_ie_in;
            cur.il <= ccr_il_in;
        end else if (do_push) begin
            cur.il <= win_lvl;
        end
    end

    // Registered take strobe, source index and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take     <= 1'b0;
            take_src <= '0;
            stk_err  <= 1'b0;
        end else begin
            take     <= do_push;
            take_src <= do_push ? win_idx : '0;
            stk_err  <= err_nxt;
        end
    end

    assign ccr_ie = cur.ie;
    assign ccr_il = cur.il;
endmodule

// File: rtl/nic_checker.sv
// Property checker for nest_irq_ctrl, attached by bind.
// Observes ports only; keeps one-cycle copies of inputs for look-back.
module nic_checker #(
    parameter int NUM_SRC = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         irq_req,
    input logic [2*NUM_SRC-1:0]       irq_lvl,
    input logic                       ccr_wr,
    input logic                       ccr_ie_in,
    input logic [1:0]                 ccr_il_in,
    input logic                       ret_strobe,
    input logic                       take,
    input logic [$clog2(NUM_SRC)-1:0] take_src,
    input logic                       ccr_ie,
    input logic [1:0]                 ccr_il,
    input logic                       stk_err
);
    logic [2*NUM_SRC-1:0] lvl_q;
    logic [NUM_SRC-1:0]   req_q;
    logic [1:0]           taken_lvl;

    // One-cycle copies of the request inputs.
    always_ff @(posedge clk) begin
        lvl_q <= irq_lvl;
        req_q <= irq_req;
    end

    assign taken_lvl = lvl_q[take_src*2 +: 2];

    AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(ccr_ie)); // R2
    AST_TAKE_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(ccr_il) != 2'b00)); // R3
    AST_LEGAL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (taken_lvl != 2'b11) && (taken_lvl != 2'b00)); // R4
    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (ccr_il < $past(ccr_il))); // R5
    AST_LEVEL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (ccr_il == taken_lvl) && (ccr_ie == $past(ccr_ie))); // R7
    AST_SOURCE_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> req_q[take_src]); // R7
    AST_QUIET_ON_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ret_strobe || ccr_wr) |-> !take); // R9
    AST_WRITE_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ccr_wr && !ret_strobe) |->
            (ccr_ie == $past(ccr_ie_in)) && (ccr_il == $past(ccr_il_in))); // R9
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |-> !take && $stable(ccr_il) && $stable(ccr_ie)); // R10
endmodule

bind nest_irq_ctrl nic_checker #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_lvl    (irq_lvl),
    .ccr_wr     (ccr_wr),
    .ccr_ie_in  (ccr_ie_in),
    .ccr_il_in  (ccr_il_in),
    .ret_strobe (ret_strobe),
    .take       (take),
    .take_src   (take_src),
    .ccr_ie     (ccr_ie),
    .ccr_il     (ccr_il),
    .stk_err    (stk_err)
);

// File: tb/nest_irq_ctrl_tb_top.sv
// Bench: behavioural reference model (queue stack) compared every cycle.
module nest_irq_ctrl_tb_top;
    localparam int N  = 4;
    localparam int D  = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [2*N-1:0] irq_lvl = '0;
    logic          ccr_wr = 1'b0;
    logic          ccr_ie_in = 1'b0;
    logic [1:0]    ccr_il_in = 2'b00;
    logic          ret_strobe = 1'b0;
    logic          take;
    logic [SW-1:0] take_src;
    logic          ccr_ie;
    logic [1:0]    ccr_il;
    logic          stk_err;

    int    vectors = 0;
    int    miscompares = 0;
    string phase = "R1";
    bit    armed = 1'b0;

    bit        m_ie, m_take, m_err;
    bit [1:0]  m_il;
    bit [SW-1:0] m_src;
    bit [2:0]  stk[$];

    always #5 clk = ~clk;

    nest_irq_ctrl #(.NUM_SRC(N), .STACK_DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .ccr_wr(ccr_wr), .ccr_ie_in(ccr_ie_in), .ccr_il_in(ccr_il_in),
        .ret_strobe(ret_strobe), .take(take), .take_src(take_src),
        .ccr_ie(ccr_ie), .ccr_il(ccr_il), .stk_err(stk_err)
    );

    // Reference model, advanced on each rising edge from the requirements.
    always @(posedge clk) begin : model
        int       bi;
        bit [1:0] best;
        bit [1:0] lv;
        bit [2:0] e;
        if (!rst_n) begin
            m_ie = 0; m_il = 2'd3; m_take = 0; m_src = 0; m_err = 0;
            stk.delete();
        end else begin
            m_take = 0; m_src = 0; m_err = 0;
            if (ret_strobe) begin
                if (stk.size() == 0) m_err = 1;
                else begin e = stk.pop_back(); m_ie = e[2]; m_il = e[1:0]; end
            end else if (ccr_wr) begin
                m_ie = ccr_ie_in; m_il = ccr_il_in;
            end else begin
                best = 2'd3; bi = -1;
                for (int i = 0; i < N; i++) begin
                    lv = irq_lvl[2*i +: 2];
                    if (irq_req[i] && m_ie && lv != 0 && lv != 3 && lv < m_il && lv < best) begin
                        best = lv; bi = i;
                    end
                end
                if (bi >= 0) begin
                    if (stk.size() == D) m_err = 1;
                    else begin
                        stk.push_back({m_ie, m_il});
                        m_il = best; m_take = 1; m_src = bi[SW-1:0];
                    end
                end
            end
        end
        armed = 1'b1;
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            vectors++;
            if (take !== m_take || take_src !== m_src || ccr_ie !== m_ie ||
                ccr_il !== m_il || stk_err !== m_err) begin
                miscompares++;
                $display("FAIL %s: got take=%0b src=%0d ie=%0b il=%0d err=%0b expected take=%0b src=%0d ie=%0b il=%0d err=%0b",
                         phase, take, take_src, ccr_ie, ccr_il, stk_err,
                         m_take, m_src, m_ie, m_il, m_err);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_val(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sw_write(input bit ie, input bit [1:0] il);
        ccr_wr = 1; ccr_ie_in = ie; ccr_il_in = il;
        cyc(1);
        ccr_wr = 0;
    endtask

    task automatic ret(input int n);
        for (int k = 0; k < n; k++) begin
            ret_strobe = 1; cyc(1); ret_strobe = 0; cyc(1);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        miscompares++;
        $display("FAIL R1: watchdog got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stimulus
        cyc(3);
        rst_n = 1;
        cyc(1);
        expect_val("R1 level after reset", ccr_il, 3);

        phase = "R2";
        irq_lvl = 8'b01_01_01_01; irq_req = 4'b1111;
        cyc(3);
        irq_req = 0;

        phase = "R9";
        sw_write(1, 2'b00);
        phase = "R3";
        irq_req = 4'b1111;
        cyc(3);
        irq_req = 0;

        phase = "R4";
        irq_lvl = 8'b00_11_00_11;
        sw_write(1, 2'b11);
        irq_req = 4'b1111;
        cyc(3);
        irq_req = 0;

        phase = "R6";
        irq_lvl = 8'b01_01_10_10;
        irq_req = 4'b1111;
        cyc(1);
        irq_req = 0;
        expect_val("R6 winner index", take_src, 2);
        cyc(2);
        phase = "R8";
        ret(1);
        phase = "R11";
        ret(1);

        phase = "R5";
        irq_req = 4'b0001;
        cyc(4);
        irq_req = 4'b0101;
        cyc(1);
        expect_val("R5 preempt level", ccr_il, 1);
        irq_req = 0;
        cyc(1);
        phase = "R8";
        ret(2);

        phase = "R10";
        for (int k = 0; k < D; k++) begin
            irq_req = 4'b0100; cyc(1); irq_req = 0;
            sw_write(1, (k % 2 == 0) ? 2'b10 : 2'b11);
        end
        irq_req = 4'b0100; cyc(1); irq_req = 0;
        expect_val("R10 overflow error", stk_err, 1);
        cyc(1);
        phase = "R8";
        ret(D);
        phase = "R11";
        ret(1);

        phase = "R7";
        for (int k = 0; k < 3000; k++) begin
            irq_req    = N'($urandom);
            if ($urandom % 8 == 0) irq_lvl = (2*N)'($urandom);
            ret_strobe = ($urandom % 8 == 0);
            ccr_wr     = ($urandom % 12 == 0);
            ccr_ie_in  = ($urandom % 4 != 0);
            ccr_il_in  = 2'($urandom);
            cyc(1);
        end
        irq_req = 0; ret_strobe = 0; ccr_wr = 0;
        cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule